// File: doc/BRIEF.md
# USB Low/Full-Speed Line Symbol Sampler

This block watches an oversampled differential USB pair (D+ and D-) that has already been brought into the local sample clock domain. On every clock it turns the pair into one of four line symbols. Which level pair counts as J and which as K depends on the speed input, because the two speeds use opposite polarity. While idle the block waits for the line to move from J to K. That transition marks the start of a packet and fixes the timing origin.

From the origin onward the block presents one symbol per bit cell, taken at the centre of the cell. The centre lies half a bit width after the origin plus a whole number of bit widths. The block never re-aligns to later edges. A sampled SE0 moves it into end-of-packet wait. A following J completes the packet. Any other symbol after the SE0 abandons the packet. In both cases the block goes back to idle.

Downstream logic (NRZI decoding, bit unstuffing, packet parsing) consumes the symbol strobe, the start pulse and the end pulse.

Top module: `usb_line_sampler`

## Requirements
- R1: In full-speed mode (ls_mode_i=0) the symbol code is SE0=0 for D+=0,D-=0; J=1 for D+=1,D-=0; K=2 for D+=0,D-=1; SE1=3 for D+=1,D-=1.
- R2: In low-speed mode (ls_mode_i=1) the J and K level pairs are swapped: J=1 for D+=0,D-=1 and K=2 for D+=1,D-=0. The codes for SE0 and SE1 do not change.
- R3: After reset and while idle, sym_vld_o, sop_o and eop_o are 0. The remembered previous symbol starts as J. Idle line activity other than a J-to-K change (SE0, SE1, SE1-to-K) produces no pulse and no strobe.
- R4: While idle, a sample that shows K right after a sample that showed J starts a packet. sop_o is high for exactly one cycle, in the cycle after that sample (the origin).
- R5: With W = FS_BIT_CLKS in full-speed mode or LS_BIT_CLKS in low-speed mode, and H = W/2 truncated, symbol n is sampled at origin + H + n*W clocks. sym_vld_o is high for one cycle in the cycle after that sample.
- R6: Every sampled symbol from the start of the packet up to and including the end-of-packet J is presented on sym_o with a sym_vld_o strobe, using the codes of R1/R2.
- R7: A sampled SE0 during reception enters end-of-packet wait. Further sampled SE0 symbols keep the block in that wait.
- R8: A sampled J during end-of-packet wait raises eop_o together with that J's strobe and returns the block to idle. A later J-to-K change starts a new packet.
- R9: A sampled K or SE1 during end-of-packet wait abandons the packet. eop_o stays 0 and the block returns to idle.
- R10: sop_o never coincides with sym_vld_o, and sop_o never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| ls_mode_i | input | 1 | 1 = low-speed, 0 = full-speed; hold stable during a packet |
| sym_vld_o | output | 1 | One-cycle strobe: a mid-bit symbol is on sym_o |
| sym_o | output | 2 | Sampled symbol: 0 SE0, 1 J, 2 K, 3 SE1 |
| sop_o | output | 1 | One-cycle pulse after the start-of-packet sample |
| eop_o | output | 1 | One-cycle pulse with the strobe of the completing J |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- The bit counter stays inside its cell.
- Strobes appear only outside idle.
- The start pulse is a single cycle and never lands on a strobe.
- An end pulse always carries a J strobe.
- An abandoned end-of-packet wait lands in idle without an end pulse.

Some behaviour can only be shown by the directed scenarios, because it depends on the stimulus:
- The exact sampling cycle of each cell relative to the origin, in both speeds.
- The polarity swap between speeds.
- The symbol sequence reported for whole packets.
- Idle noise being ignored.
- A second packet being caught after an abort.

// File: rtl/usbl_pkg.sv
package usbl_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'd0,
    SYM_J   = 2'd1,
    SYM_K   = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_EOPW = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usbl_line_class.sv
module usbl_line_class
  import usbl_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      ls_mode_i,
  output line_sym_e sym_o
);
  // Differential pair to symbol; the J/K meaning flips with speed (R1, R2)
  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   sym_o = SYM_SE0;
      2'b11:   sym_o = SYM_SE1;
      2'b10:   sym_o = ls_mode_i ? SYM_K : SYM_J;
      default: sym_o = ls_mode_i ? SYM_J : SYM_K;
    endcase
  end
endmodule

// File: rtl/usbl_bit_timer.sv
module usbl_bit_timer #(
  parameter int FS_BIT_CLKS = 4,
  parameter int LS_BIT_CLKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic ls_mode_i,
  output logic tick_o
);
  localparam int MAX_W = (LS_BIT_CLKS > FS_BIT_CLKS) ? LS_BIT_CLKS : FS_BIT_CLKS;
  localparam int CW    = $clog2(MAX_W);
  localparam logic [CW-1:0] FS_HALF_M1 = CW'(FS_BIT_CLKS / 2 - 1);
  localparam logic [CW-1:0] LS_HALF_M1 = CW'(LS_BIT_CLKS / 2 - 1);
  localparam logic [CW-1:0] FS_FULL_M1 = CW'(FS_BIT_CLKS - 1);
  localparam logic [CW-1:0] LS_FULL_M1 = CW'(LS_BIT_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == '0);
  assign cnt_en = start_i || run_i;

  // Origin-relative countdown: half a cell first, then whole cells (R5)
  always_comb begin
    cnt_d = cnt_q;
    if (start_i)
      cnt_d = ls_mode_i ? LS_HALF_M1 : FS_HALF_M1;
    else if (tick_o)
      cnt_d = ls_mode_i ? LS_FULL_M1 : FS_FULL_M1;
    else if (run_i)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_in_cell_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= (ls_mode_i ? LS_FULL_M1 : FS_FULL_M1)));
  assert_tick_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> !start_i);
endmodule

// File: rtl/usbl_rx_ctrl.sv
module usbl_rx_ctrl
  import usbl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  line_sym_e  sym_i,
  input  logic       tick_i,
  output logic       start_o,
  output logic       run_o,
  output logic       sym_vld_o,
  output logic [1:0] sym_o,
  output logic       sop_o,
  output logic       eop_o
);
  rx_state_e state_q, state_d;
  line_sym_e prev_q, sym_q, sym_d;
  logic      vld_q, sop_q, eop_q, eop_d;

  assign start_o = (state_q == ST_IDLE) && (prev_q == SYM_J) && (sym_i == SYM_K);
  assign run_o   = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    eop_d   = 1'b0;
    sym_d   = tick_i ? sym_i : sym_q;
    unique case (state_q)
      ST_IDLE: if (start_o) state_d = ST_RECV;                      // R4
      ST_RECV: if (tick_i && sym_i == SYM_SE0) state_d = ST_EOPW;   // R7
      ST_EOPW: if (tick_i) begin
        if (sym_i == SYM_J) begin                                   // R8
          state_d = ST_IDLE;
          eop_d   = 1'b1;
        end else if (sym_i != SYM_SE0) begin                        // R9
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prev_q  <= SYM_J;                                             // R3
      sym_q   <= SYM_SE0;
      vld_q   <= 1'b0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= sym_i;
      sym_q   <= sym_d;
      vld_q   <= tick_i;
      sop_q   <= start_o;
      eop_q   <= eop_d;
    end
  end

  assign sym_vld_o = vld_q;
  assign sym_o     = sym_q;
  assign sop_o     = sop_q;
  assign eop_o     = eop_q;

  assert_strobe_outside_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(state_q) != ST_IDLE);
  assert_sop_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_q |=> !sop_q);
  assert_sop_not_on_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_q |-> !vld_q);
  assert_eop_carries_j_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_q |-> (vld_q && sym_q == SYM_J && state_q == ST_IDLE));
  assert_abort_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOPW && tick_i && sym_i != SYM_SE0 && sym_i != SYM_J)
      |=> (state_q == ST_IDLE && !eop_q));
endmodule

// File: rtl/usb_line_sampler.sv
module usb_line_sampler
  import usbl_pkg::*;
#(
  parameter int FS_BIT_CLKS = 4,
  parameter int LS_BIT_CLKS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       ls_mode_i,
  output logic       sym_vld_o,
  output logic [1:0] sym_o,
  output logic       sop_o,
  output logic       eop_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  line_sym_e  line_sym;
  logic       start, run, tick;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  usbl_line_class class_i (
    .dp_i      (dp_i),
    .dm_i      (dm_i),
    .ls_mode_i (ls_mode_i),
    .sym_o     (line_sym)
  );

  usbl_bit_timer #(
    .FS_BIT_CLKS (FS_BIT_CLKS),
    .LS_BIT_CLKS (LS_BIT_CLKS)
  ) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .start_i   (start),
    .run_i     (run),
    .ls_mode_i (ls_mode_i),
    .tick_o    (tick)
  );

  usbl_rx_ctrl ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .sym_i     (line_sym),
    .tick_i    (tick),
    .start_o   (start),
    .run_o     (run),
    .sym_vld_o (sym_vld_o),
    .sym_o     (sym_o),
    .sop_o     (sop_o),
    .eop_o     (eop_o)
  );
endmodule

// File: tb/usb_line_sampler_tb_top.sv
module usb_line_sampler_tb_top;
  localparam int FSW = 4;
  localparam int LSW = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b1, dm = 1'b0, ls = 1'b0;
  logic       sym_vld, sop, eop;
  logic [1:0] sym;

  int tests = 0, fails = 0, cyc = 0;
  int log_n = 0, sop_n = 0, eop_n = 0, sop_cyc = 0, eop_cyc = 0;
  int log_cyc [0:31];
  int log_sym [0:31];
  logic [1:0] pkt [0:15];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_line_sampler #(.FS_BIT_CLKS(FSW), .LS_BIT_CLKS(LSW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .ls_mode_i(ls),
    .sym_vld_o(sym_vld), .sym_o(sym), .sop_o(sop), .eop_o(eop)
  );

  always @(negedge clk) begin
    if (sym_vld && log_n < 32) begin
      log_cyc[log_n] = cyc;
      log_sym[log_n] = int'(sym);
      log_n++;
    end
    if (sop) begin sop_n++; sop_cyc = cyc; end
    if (eop) begin eop_n++; eop_cyc = cyc; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    log_n = 0; sop_n = 0; eop_n = 0;
  endtask

  // code: 0 SE0, 1 J, 2 K, 3 SE1; polarity per speed
  task automatic drive_sym(input logic [1:0] code, input int n);
    case (code)
      2'd0: {dp, dm} = 2'b00;
      2'd3: {dp, dm} = 2'b11;
      2'd1: {dp, dm} = ls ? 2'b01 : 2'b10;
      default: {dp, dm} = ls ? 2'b10 : 2'b01;
    endcase
    repeat (n) @(negedge clk);
  endtask

  task automatic run_pkt(input bit lsm, input int n, input bit want_eop, input string req);
    int w, h, origin;
    ls = lsm;
    w = lsm ? LSW : FSW;
    h = w / 2;
    drive_sym(2'd1, 6);
    clear_logs();
    origin = cyc + 1;
    for (int i = 0; i < n; i++) drive_sym(pkt[i], w);
    drive_sym(2'd1, 3 * w);
    check(sop_n == 1, "R4", "sop count", sop_n, 1);
    check(sop_cyc == origin, "R4", "sop cycle", sop_cyc, origin);
    check(log_n == n, req, "strobe count", log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      check(log_cyc[i] == origin + h + i * w, "R5", "strobe cycle", log_cyc[i], origin + h + i * w);
      check(log_sym[i] == int'(pkt[i]), req, "symbol", log_sym[i], int'(pkt[i]));
    end
    check(eop_n == (want_eop ? 1 : 0), want_eop ? "R8" : "R9", "eop count", eop_n, want_eop ? 1 : 0);
    if (want_eop && log_n > 0)
      check(eop_cyc == log_cyc[log_n-1], "R8", "eop cycle", eop_cyc, log_cyc[log_n-1]);
  endtask

  task automatic t_reset();
    check(sym_vld == 1'b0 && sop == 1'b0 && eop == 1'b0, "R3", "outputs in reset",
          int'({sym_vld, sop, eop}), 0);
    rst_n = 1'b1;
    clear_logs();
    drive_sym(2'd1, 10);
    check(log_n == 0 && sop_n == 0, "R3", "idle J activity", log_n + sop_n, 0);
  endtask

  task automatic t_fs_packet();
    pkt[0] = 2'd2; pkt[1] = 2'd1; pkt[2] = 2'd2; pkt[3] = 2'd2;
    pkt[4] = 2'd1; pkt[5] = 2'd3; pkt[6] = 2'd0; pkt[7] = 2'd0; pkt[8] = 2'd1;
    run_pkt(1'b0, 9, 1'b1, "R1");
  endtask

  task automatic t_ls_packet();
    pkt[0] = 2'd2; pkt[1] = 2'd2; pkt[2] = 2'd1; pkt[3] = 2'd0; pkt[4] = 2'd1;
    run_pkt(1'b1, 5, 1'b1, "R2");
  endtask

  task automatic t_abort_then_next();
    pkt[0] = 2'd2; pkt[1] = 2'd1; pkt[2] = 2'd0; pkt[3] = 2'd2;
    run_pkt(1'b0, 4, 1'b0, "R9");
    pkt[0] = 2'd2; pkt[1] = 2'd0; pkt[2] = 2'd3;
    run_pkt(1'b0, 3, 1'b0, "R9");
    pkt[0] = 2'd2; pkt[1] = 2'd2; pkt[2] = 2'd0; pkt[3] = 2'd1;
    run_pkt(1'b0, 4, 1'b1, "R8");
  endtask

  task automatic t_idle_noise();
    ls = 1'b0;
    drive_sym(2'd1, 4);
    clear_logs();
    drive_sym(2'd0, 5);
    drive_sym(2'd3, 4);
    drive_sym(2'd2, 4);
    drive_sym(2'd0, 3);
    drive_sym(2'd2, 3);
    drive_sym(2'd1, 8);
    check(sop_n == 0, "R3", "sop on idle noise", sop_n, 0);
    check(log_n == 0, "R3", "strobe on idle noise", log_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fs_packet();
    t_ls_packet();
    t_abort_then_next();
    t_idle_noise();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule